// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block is an asynchronous serial transmitter and receiver that share one programmable baud divider. The divider turns the reference clock into an oversampling tick. Each serial bit lasts 16 ticks in normal mode and 8 ticks in high-speed mode. The character length, parity mode and stop-bit count are set through configuration ports. These ports are sampled when a character starts. Bytes enter the transmitter through a valid/ready handshake and leave the receiver as a one-cycle strobe. Each received byte carries its own framing, parity and break flags.

The transmitter can hold the line low on request, which sends a line break. The receiver finds the start of a character from a falling edge and confirms it half a bit later. It then samples each following bit at its centre. A character that stays low from its start bit through its first stop bit is reported as a break.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset, `tx_ser` is high, `tx_ready` is high and `rx_valid` is low.
- R2: The oversampling tick has a period of `cfg_div`+1 clock cycles. One serial bit lasts 16 ticks when `cfg_hs` is 0 and 8 ticks when `cfg_hs` is 1.
- R3: A frame is one low start bit, then the data bits with the least significant bit first, then high stop bits. The number of data bits is 5, 6, 7 or 8 for `cfg_len` codes 0, 1, 2 and 3. `cfg_stop2`=1 gives two stop bits and 0 gives one. The idle line is high.
- R4: When `cfg_par_en`=1 and `cfg_par_stick`=0, a parity bit follows the data bits. It makes the count of ones even when `cfg_par_even`=1 and odd when `cfg_par_even`=0. The count covers only the data bits in use. When `cfg_par_en`=0, no parity bit is sent or expected.
- R5: With `cfg_par_en`=1 and `cfg_par_stick`=1, the parity bit is the constant 1 when `cfg_par_even`=0 and the constant 0 when `cfg_par_even`=1. The receiver checks the incoming bit against the same constant.
- R6: The receiver gives back each character on a one-cycle `rx_valid` pulse. The data bits above the configured length read as zero.
- R7: `rx_perr` is set when the received parity bit differs from the expected one. It is never set while parity is disabled.
- R8: `rx_ferr` is set when the first stop bit is sampled low. The data byte is still delivered.
- R9: While `tx_break` is high, `tx_ser` is low from the next cycle on and `tx_ready` is low.
- R10: If the line stays low from the start bit through the first stop bit, the character is reported with `rx_brk`=1, `rx_ferr`=1 and `rx_data`=0. No further character is reported until the line has returned high.
- R11: After a byte is accepted (`tx_valid` and `tx_ready` both high), `tx_ready` stays low until the last stop bit has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Baud divider: tick period is cfg_div+1 clocks |
| cfg_hs | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 ticks per bit |
| cfg_len | input | 2 | Data length code: 0..3 gives 5..8 bits |
| cfg_par_en | input | 1 | Enables the parity bit |
| cfg_par_even | input | 1 | Selects even parity, or the stick value 0 |
| cfg_par_stick | input | 1 | Selects constant (stick) parity |
| cfg_stop2 | input | 1 | Transmit two stop bits |
| tx_break | input | 1 | Forces the serial output low |
| tx_valid | input | 1 | A byte is offered for transmission |
| tx_ready | output | 1 | The transmitter can accept a byte |
| tx_data | input | 8 | Byte to transmit |
| tx_ser | output | 1 | Serial output |
| rx_ser | input | 1 | Serial input (asynchronous) |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_data | output | 8 | Received byte |
| rx_ferr | output | 1 | Framing error on this character |
| rx_perr | output | 1 | Parity error on this character |
| rx_brk | output | 1 | This character is a line break |

## Verification
The bench uses the default DIV_W of 16 but drives small divider values: 1 in normal mode, which gives 32-clock bits, and 2 in high-speed mode, which gives 24-clock bits. Whole frames therefore take a few hundred cycles, so every length, parity and stop-bit combination can be sent through a loopback and also sampled directly on `tx_ser`. A bench-side line override injects frames with a wrong parity bit or a low stop bit. The break generator is looped back into the receiver so that break detection and the return to idle are exercised.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_HOLD
  } fe_state_t;

  // Mask of the data bits in use for a length code (0..3 -> 5..8 bits)
  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  // Expected parity bit for the configured mode
  function automatic logic calc_parity(input logic [7:0] d, input logic [1:0] len,
                                       input logic even, input logic stick);
    if (stick) return ~even;
    return (^(d & len_mask(len))) ^ ~even;
  endfunction

  // Index of the last data bit for a length code
  function automatic logic [2:0] last_idx(input logic [1:0] len);
    return {1'b0, len} + 3'd4;
  endfunction

endpackage

// File: rtl/uart_fe_baud.sv
module uart_fe_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;

  always_comb begin
    tick_d = (cnt_q >= div);
    cnt_d  = tick_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
  import uart_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hs,
  input  logic [1:0] len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       stop2,
  input  logic       brk,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       ser
);
  fe_state_t  st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [2:0] idx_q, idx_d;
  logic [7:0] sh_q, sh_d;
  logic [1:0] len_q, len_d;
  logic       hs_q, hs_d, pe_q, pe_d, ev_q, ev_d, sk_q, sk_d, s2_q, s2_d;
  logic       second_q, second_d;
  logic       ser_q, ser_d;
  logic       accept, bit_end;
  logic [3:0] last_cnt;

  assign in_ready = (st_q == S_IDLE) && !brk;
  assign accept   = in_valid && in_ready;
  assign last_cnt = hs_q ? 4'd7 : 4'd15;
  assign bit_end  = tick && (cnt_q == last_cnt);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; idx_d = idx_q; sh_d = sh_q;
    len_d = len_q; hs_d = hs_q; pe_d = pe_q; ev_d = ev_q; sk_d = sk_q; s2_d = s2_q;
    second_d = second_q;
    if (st_q == S_IDLE) begin
      if (accept) begin
        st_d = S_START; cnt_d = '0; sh_d = in_data;
        len_d = len; hs_d = hs; pe_d = par_en; ev_d = par_even;
        sk_d = par_stick; s2_d = stop2;
      end
    end else if (tick) begin
      cnt_d = bit_end ? 4'd0 : cnt_q + 4'd1;
      if (bit_end) begin
        case (st_q)
          S_START: begin st_d = S_DATA; idx_d = '0; end
          S_DATA: begin
            if (idx_q == last_idx(len_q)) begin
              st_d = pe_q ? S_PAR : S_STOP;
              second_d = 1'b0;
            end else begin
              idx_d = idx_q + 3'd1;
            end
          end
          S_PAR: begin st_d = S_STOP; second_d = 1'b0; end
          S_STOP: begin
            if (s2_q && !second_q) second_d = 1'b1;
            else st_d = S_IDLE;
          end
          default: st_d = S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (st_d)
      S_START: ser_d = 1'b0;
      S_DATA:  ser_d = sh_d[idx_d];
      S_PAR:   ser_d = calc_parity(sh_q, len_q, ev_q, sk_q);
      default: ser_d = 1'b1;
    endcase
    if (brk) ser_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0;
      len_q <= '0; hs_q <= 1'b0; pe_q <= 1'b0; ev_q <= 1'b0; sk_q <= 1'b0;
      s2_q <= 1'b0; second_q <= 1'b0; ser_q <= 1'b1;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; idx_q <= idx_d; sh_q <= sh_d;
      len_q <= len_d; hs_q <= hs_d; pe_q <= pe_d; ev_q <= ev_d; sk_q <= sk_d;
      s2_q <= s2_d; second_q <= second_d; ser_q <= ser_d;
    end
  end

  assign ser = ser_q;
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hs,
  input  logic [1:0] len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       ser_in,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_ferr,
  output logic       out_perr,
  output logic       out_brk
);
  logic       sy1_q, sy2_q, rxs;
  fe_state_t  st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [2:0] idx_q, idx_d;
  logic [7:0] data_q, data_d;
  logic       allz_q, allz_d, perr_q, perr_d;
  logic       vld_q, vld_d, fe_q, fe_d, pe_q, pe_d, bk_q, bk_d;
  logic [7:0] do_q, do_d;
  logic [3:0] half_cnt, last_cnt;
  logic       bit_end;

  assign rxs      = sy2_q;
  assign half_cnt = hs ? 4'd3 : 4'd7;
  assign last_cnt = hs ? 4'd7 : 4'd15;
  assign bit_end  = tick && (cnt_q == last_cnt);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; idx_d = idx_q; data_d = data_q;
    allz_d = allz_q; perr_d = perr_q;
    vld_d = 1'b0; fe_d = fe_q; pe_d = pe_q; bk_d = bk_q; do_d = do_q;
    case (st_q)
      S_IDLE: begin
        if (tick && !rxs) begin st_d = S_START; cnt_d = '0; end
      end
      S_START: begin
        if (tick) begin
          if (cnt_q == half_cnt) begin
            cnt_d = '0;
            if (!rxs) begin
              st_d = S_DATA; idx_d = '0; data_d = '0; allz_d = 1'b1; perr_d = 1'b0;
            end else begin
              st_d = S_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
      end
      S_DATA, S_PAR, S_STOP: begin
        if (tick) cnt_d = bit_end ? 4'd0 : cnt_q + 4'd1;
        if (bit_end) begin
          allz_d = allz_q & ~rxs;
          if (st_q == S_DATA) begin
            data_d[idx_q] = rxs;
            if (idx_q == last_idx(len)) st_d = par_en ? S_PAR : S_STOP;
            else idx_d = idx_q + 3'd1;
          end else if (st_q == S_PAR) begin
            perr_d = (rxs != calc_parity(data_q, len, par_even, par_stick));
            st_d = S_STOP;
          end else begin
            vld_d = 1'b1;
            do_d  = data_q;
            fe_d  = ~rxs;
            pe_d  = perr_q;
            bk_d  = allz_q & ~rxs;
            st_d  = rxs ? S_IDLE : S_HOLD;
          end
        end
      end
      S_HOLD: begin
        if (rxs) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= 1'b1; sy2_q <= 1'b1;
      st_q <= S_IDLE; cnt_q <= '0; idx_q <= '0; data_q <= '0;
      allz_q <= 1'b0; perr_q <= 1'b0;
      vld_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0; bk_q <= 1'b0; do_q <= '0;
    end else begin
      sy1_q <= ser_in; sy2_q <= sy1_q;
      st_q <= st_d; cnt_q <= cnt_d; idx_q <= idx_d; data_q <= data_d;
      allz_q <= allz_d; perr_q <= perr_d;
      vld_q <= vld_d; fe_q <= fe_d; pe_q <= pe_d; bk_q <= bk_d; do_q <= do_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = do_q;
  assign out_ferr  = fe_q;
  assign out_perr  = pe_q;
  assign out_brk   = bk_q;
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_hs,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_even,
  input  logic             cfg_par_stick,
  input  logic             cfg_stop2,
  input  logic             tx_break,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             tx_ser,
  input  logic             rx_ser,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_ferr,
  output logic             rx_perr,
  output logic             rx_brk
);
  logic tick;

  uart_fe_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
  );

  uart_fe_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hs(cfg_hs), .len(cfg_len),
    .par_en(cfg_par_en), .par_even(cfg_par_even), .par_stick(cfg_par_stick),
    .stop2(cfg_stop2), .brk(tx_break), .in_valid(tx_valid), .in_data(tx_data),
    .in_ready(tx_ready), .ser(tx_ser)
  );

  uart_fe_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hs(cfg_hs), .len(cfg_len),
    .par_en(cfg_par_en), .par_even(cfg_par_even), .par_stick(cfg_par_stick),
    .ser_in(rx_ser), .out_valid(rx_valid), .out_data(rx_data),
    .out_ferr(rx_ferr), .out_perr(rx_perr), .out_brk(rx_brk)
  );
endmodule

// File: rtl/uart_fe_checker.sv
module uart_fe_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] cfg_div,
  input logic             cfg_par_en,
  input logic             tx_break,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             tx_ser,
  input logic             rx_valid,
  input logic [7:0]       rx_data,
  input logic             rx_ferr,
  input logic             rx_perr,
  input logic             rx_brk
);
  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> tx_ser);

  assert_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_no_perr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_par_en) |-> !rx_perr);

  assert_break_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_break |=> !tx_ser);

  assert_break_char_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_brk) |-> (rx_data == 8'h00 && rx_ferr));

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind uart_frame_engine uart_fe_checker #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/uart_frame_engine_test.sv
module uart_frame_engine_test;
  localparam int DIV_W = 16;

  logic clk, rst_n;
  logic [DIV_W-1:0] cfg_div;
  logic cfg_hs, cfg_par_en, cfg_par_even, cfg_par_stick, cfg_stop2;
  logic [1:0] cfg_len;
  logic tx_break, tx_valid, tx_ready, tx_ser;
  logic [7:0] tx_data, rx_data;
  logic rx_valid, rx_ferr, rx_perr, rx_brk;
  logic ovr_en, ovr_val, rx_line;

  int checks = 0;
  int fails = 0;
  logic [10:0] expq[$];   // {data, ferr, perr, brk}

  assign rx_line = ovr_en ? ovr_val : tx_ser;

  uart_frame_engine #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_hs(cfg_hs), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_par_stick(cfg_par_stick),
    .cfg_stop2(cfg_stop2), .tx_break(tx_break), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_ser(tx_ser), .rx_ser(rx_line), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_brk(rx_brk)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bit_period();
    return (int'(cfg_div) + 1) * (cfg_hs ? 8 : 16);
  endfunction

  function automatic logic [7:0] bmask();
    return 8'hFF >> (3 - int'(cfg_len));
  endfunction

  function automatic logic bpar(input logic [7:0] d);
    if (cfg_par_stick) return ~cfg_par_even;
    return (^(d & bmask())) ^ ~cfg_par_even;
  endfunction

  // Monitor: pop expected characters as the receiver delivers them
  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R10 R6 unexpected character", {rx_data, rx_ferr, rx_perr, rx_brk}, 0);
        end else begin
          logic [10:0] e;
          e = expq.pop_front();
          chk(rx_data == e[10:3], "R6 rx data", rx_data, e[10:3]);
          chk(rx_ferr == e[2], "R8 rx framing flag", rx_ferr, e[2]);
          chk(rx_perr == e[1], "R7 rx parity flag", rx_perr, e[1]);
          chk(rx_brk == e[0], "R10 rx break flag", rx_brk, e[0]);
        end
      end
    end
  end

  // Driver: send one byte, sniff the serial line, queue the expected character
  task automatic send_byte(input logic [7:0] d);
    int bp, nb;
    bp = bit_period();
    nb = int'(cfg_len) + 5;
    expq.push_back({d & bmask(), 3'b000});
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(!tx_ready, "R11 busy after accept", tx_ready, 0);
    while (tx_ser) @(negedge clk);
    repeat (bp / 2) @(negedge clk);
    chk(tx_ser == 1'b0, "R3 start bit", tx_ser, 0);
    for (int i = 0; i < nb; i++) begin
      repeat (bp) @(negedge clk);
      chk(tx_ser == d[i], "R2 R3 data bit", tx_ser, d[i]);
    end
    if (cfg_par_en) begin
      repeat (bp) @(negedge clk);
      chk(tx_ser == bpar(d), cfg_par_stick ? "R5 stick parity bit" : "R4 parity bit",
          tx_ser, bpar(d));
    end
    repeat (bp) @(negedge clk);
    chk(tx_ser == 1'b1, "R3 first stop bit", tx_ser, 1);
    if (cfg_stop2) begin
      repeat (bp) @(negedge clk);
      chk(tx_ser == 1'b1 && !tx_ready, "R3 R11 second stop bit", {tx_ser, tx_ready}, 2);
    end
    while (!tx_ready) @(negedge clk);
  endtask

  // Raw frame on the receive line, LSB of bits first
  task automatic drive_raw(input logic [15:0] bits, input int n);
    int bp;
    bp = bit_period();
    @(negedge clk);
    ovr_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      ovr_val = bits[i];
      repeat (bp) @(negedge clk);
    end
    ovr_val = 1'b1;
    repeat (2 * bp) @(negedge clk);
    ovr_en = 1'b0;
  endtask

  task automatic set_cfg(input int div, input logic hs, input logic [1:0] len,
                         input logic pe, input logic ev, input logic sk, input logic s2);
    @(negedge clk);
    cfg_div = DIV_W'(div); cfg_hs = hs; cfg_len = len;
    cfg_par_en = pe; cfg_par_even = ev; cfg_par_stick = sk; cfg_stop2 = s2;
    repeat (4) @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tx_break = 1'b0; tx_valid = 1'b0; tx_data = '0;
    ovr_en = 1'b0; ovr_val = 1'b1;
    cfg_div = DIV_W'(1); cfg_hs = 1'b0; cfg_len = 2'd3;
    cfg_par_en = 1'b0; cfg_par_even = 1'b0; cfg_par_stick = 1'b0; cfg_stop2 = 1'b0;
    repeat (5) @(negedge clk);
    chk(tx_ser == 1'b1, "R1 tx line after reset", tx_ser, 1);
    chk(tx_ready == 1'b1, "R1 ready after reset", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1 no rx strobe after reset", rx_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // 8N1, x16
    set_cfg(1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h01);
    // 5 bits, even parity, two stops (upper bits must read zero)
    set_cfg(1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1);
    send_byte(8'hF3); send_byte(8'h0E);
    // 7 bits, odd parity, high-speed x8, divider 2
    set_cfg(2, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    send_byte(8'h55); send_byte(8'hFF);
    // 6 bits, stick parity both constants
    set_cfg(1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0);
    send_byte(8'h2A);
    set_cfg(1, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0);
    send_byte(8'h15);

    // Parity error: 8 bits even, data 0x01 needs parity 1, send 0
    set_cfg(1, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
    expq.push_back({8'h01, 3'b010});
    drive_raw({5'b0, 1'b1, 1'b0, 8'h01, 1'b0}, 11);
    // Stick parity mismatch: expected 0, send 1
    set_cfg(1, 1'b0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0);
    expq.push_back({8'h40, 3'b010});
    drive_raw({5'b0, 1'b1, 1'b1, 8'h40, 1'b0}, 11);

    // Framing error: 8N1, data 0x5A, stop low
    set_cfg(1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    expq.push_back({8'h5A, 3'b100});
    drive_raw({6'b0, 1'b0, 8'h5A, 1'b0}, 10);

    // Break generation looped back into break detection
    @(negedge clk);
    tx_break = 1'b1;
    expq.push_back({8'h00, 3'b101});
    repeat (2) @(negedge clk);
    chk(tx_ser == 1'b0, "R9 break drives line low", tx_ser, 0);
    chk(tx_ready == 1'b0, "R9 not ready during break", tx_ready, 0);
    repeat (30 * bit_period()) @(negedge clk);
    chk(tx_ser == 1'b0, "R9 line still low", tx_ser, 0);
    chk(expq.size() == 0, "R10 single break report", expq.size(), 0);
    tx_break = 1'b0;
    repeat (3 * bit_period()) @(negedge clk);
    send_byte(8'hC3);

    repeat (4 * bit_period()) @(negedge clk);
    chk(expq.size() == 0, "R6 all characters received", expq.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule